// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the host write cycles on a 16-bit NOR-style flash bus and works out which command the host is issuing. A write-strobe rising edge is brought into the system clock domain and becomes a single event. On that event the address and data are decoded against the keyed unlock prefix and the command byte that follows it. The decoder keeps an operating mode for the bank last addressed: array read, identification, erase setup, erasing, erase suspended, or the bypass mode that drops the unlock prefix.

When a command completes, the decoder emits a one-cycle start pulse for program, sector erase, chip erase, suspend or resume. The pulse comes with the latched address and data. An external busy input marks an operation in progress. While busy is high, new commands are blocked, except for the suspend of a running sector erase. A falling edge of busy ends the erasing mode.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the mode output is array read and no start pulse is active. The mode encoding is 0 array read, 1 identification, 2 erase setup, 3 erasing, 4 suspended, 5 bypass.
- R2: The writes AA@555, 55@2AA, A0@555 and then any address/data give exactly one `go_program` pulse. `cmd_addr` and `cmd_data` carry the fourth write.
- R3: A write with the wrong address or data partway through a prefix returns the decoder to idle and produces no pulse. A later correct sequence is decoded normally.
- R4: Prefix then 90 enters identification mode (1) and records the bank from the top address bits. In this mode, command sequences produce no pulses.
- R5: Prefix, 80, prefix, then 10@555 gives one `go_chip_erase` pulse and mode 3. The mode reads 2 while the second half of the sequence is pending. A 10 to any other address aborts the sequence.
- R6: Prefix, 80, prefix, then 30 to any address gives one `go_sector_erase` pulse with that address, mode 3, and records the bank of that address.
- R7: B0 gives `go_suspend` and mode 4 only during a sector erase, and only when written to the recorded bank. A 30 to that bank gives `go_resume` and mode 3 only while suspended. B0 has no effect in read mode or during a chip erase.
- R8: Prefix then 20 enters bypass mode (5). In bypass, A0 followed by address/data programs, and 80 followed by 30 or 10 erases. The sequence 90 then 00 returns to mode 0.
- R9: Only data bits 7:0 and address bits 10:0 take part in key and command matching.
- R10: While busy is high, no program or erase start pulse is produced and sequences are not tracked.
- R11: In mode 3, a falling edge of busy returns the mode to 0, or to 5 if the erase was started from bypass.
- R12: F0 written at any point of a sequence, or in identification mode, clears the sequence and returns identification mode to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Host write strobe, active low; sampled on its rising edge |
| addr | input | 23 | Host word address |
| data | input | 16 | Host write data |
| busy | input | 1 | High while a program or erase operation runs |
| mode | output | 3 | Current operating mode |
| mode_bank | output | 3 | Bank recorded by identification or erase start |
| go_program | output | 1 | One-cycle program start |
| go_sector_erase | output | 1 | One-cycle sector erase start |
| go_chip_erase | output | 1 | One-cycle chip erase start |
| go_suspend | output | 1 | One-cycle erase suspend |
| go_resume | output | 1 | One-cycle erase resume |
| cmd_addr | output | 23 | Address latched with the last pulse |
| cmd_data | output | 16 | Data latched with the last pulse |

## Verification
The assertions watch, on every cycle, that at most one start pulse is active and that a write edge yields a single event. They also check that suspend and resume only move between the erasing and suspended modes, that no start pulse follows a busy cycle, and that identification mode is left only for array read. Only the directed scenarios can show the following: that a complete keyed sequence yields its pulse with the right address and data, that a wrong cycle aborts, and that bank matching selects which suspend is honoured. They also cover the masking of upper address and data bits, and the return to bypass after an erase finishes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    MD_READ       = 3'd0,
    MD_AUTOSEL    = 3'd1,
    MD_ERASE_PEND = 3'd2,
    MD_ERASING    = 3'd3,
    MD_SUSPENDED  = 3'd4,
    MD_BYPASS     = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PROG,
    SQ_EKEY1,
    SQ_EKEY2,
    SQ_ECONF,
    SQ_BYPX
  } seq_e;

  localparam logic [7:0] OP_KEY_A = 8'hAA;
  localparam logic [7:0] OP_KEY_B = 8'h55;
  localparam logic [7:0] OP_RESET = 8'hF0;
  localparam logic [7:0] OP_IDENT = 8'h90;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_ERASE = 8'h80;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_SECT  = 8'h30;
  localparam logic [7:0] OP_SUSP  = 8'hB0;
  localparam logic [7:0] OP_BYP   = 8'h20;
  localparam logic [7:0] OP_BYPX  = 8'h00;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

endpackage

// File: rtl/flash_strobe_sync.sv
module flash_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic ev
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], wr_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign ev = sync_q[STAGES-1] & ~last_q;

  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> !ev); // R2

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned KEY_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  output logic [2:0]        mode,
  output logic [BANK_W-1:0] mode_bank,
  output logic              go_program,
  output logic              go_sector_erase,
  output logic              go_chip_erase,
  output logic              go_suspend,
  output logic              go_resume,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam logic [KEY_W-1:0] KEY_A = KEY_W'(KEY_ADDR_A);
  localparam logic [KEY_W-1:0] KEY_B = KEY_W'(KEY_ADDR_B);

  logic [7:0]        op;
  logic [BANK_W-1:0] abank;
  logic              at_a, at_b;

  assign op    = data[7:0];
  assign abank = addr[ADDR_W-1 -: BANK_W];
  assign at_a  = (addr[KEY_W-1:0] == KEY_A);
  assign at_b  = (addr[KEY_W-1:0] == KEY_B);

  mode_e             mode_q, mode_n;
  seq_e              seq_q, seq_n;
  logic              byp_q, byp_n, sec_q, sec_n, busy_q;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic              p_prog, p_sect, p_chip, p_susp, p_res, cap_en;

  always_comb begin
    mode_n = mode_q;
    seq_n  = seq_q;
    byp_n  = byp_q;
    sec_n  = sec_q;
    bank_n = bank_q;
    p_prog = 1'b0;
    p_sect = 1'b0;
    p_chip = 1'b0;
    p_susp = 1'b0;
    p_res  = 1'b0;
    if (mode_q == MD_ERASING && busy_q && !busy) begin
      mode_n = byp_q ? MD_BYPASS : MD_READ;
      seq_n  = SQ_IDLE;
    end else if (ev) begin
      if (mode_q == MD_ERASING) begin
        if (op == OP_SUSP && sec_q && abank == bank_q) begin
          mode_n = MD_SUSPENDED;
          p_susp = 1'b1;
        end
      end else if (mode_q == MD_SUSPENDED) begin
        if (op == OP_SECT && abank == bank_q) begin
          mode_n = MD_ERASING;
          p_res  = 1'b1;
        end
      end else if (!busy) begin
        if (seq_q == SQ_PROG) begin
          p_prog = 1'b1;
          seq_n  = SQ_IDLE;
        end else if (op == OP_RESET) begin
          seq_n = SQ_IDLE;
          if (mode_q == MD_AUTOSEL) mode_n = MD_READ;
        end else begin
          seq_n = SQ_IDLE;
          unique case (seq_q)
            SQ_IDLE: begin
              if (mode_q == MD_BYPASS) begin
                if (op == OP_PROG)       seq_n = SQ_PROG;
                else if (op == OP_ERASE) seq_n = SQ_ECONF;
                else if (op == OP_IDENT) seq_n = SQ_BYPX;
              end else if (mode_q == MD_READ && at_a && op == OP_KEY_A) begin
                seq_n = SQ_KEY1;
              end
            end
            SQ_KEY1: if (at_b && op == OP_KEY_B) seq_n = SQ_KEY2;
            SQ_KEY2: begin
              if (at_a) begin
                if (op == OP_IDENT) begin
                  mode_n = MD_AUTOSEL;
                  bank_n = abank;
                end else if (op == OP_PROG) begin
                  seq_n = SQ_PROG;
                end else if (op == OP_ERASE) begin
                  seq_n = SQ_EKEY1;
                end else if (op == OP_BYP) begin
                  mode_n = MD_BYPASS;
                  byp_n  = 1'b1;
                end
              end
            end
            SQ_EKEY1: if (at_a && op == OP_KEY_A) seq_n = SQ_EKEY2;
            SQ_EKEY2: if (at_b && op == OP_KEY_B) seq_n = SQ_ECONF;
            SQ_ECONF: begin
              if (op == OP_CHIP && at_a) begin
                p_chip = 1'b1;
                mode_n = MD_ERASING;
                sec_n  = 1'b0;
                bank_n = abank;
              end else if (op == OP_SECT) begin
                p_sect = 1'b1;
                mode_n = MD_ERASING;
                sec_n  = 1'b1;
                bank_n = abank;
              end
            end
            SQ_BYPX: begin
              if (op == OP_BYPX) begin
                mode_n = MD_READ;
                byp_n  = 1'b0;
              end
            end
            default: seq_n = SQ_IDLE;
          endcase
        end
      end
    end
  end

  assign cap_en = p_prog | p_sect | p_chip | p_susp | p_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q          <= MD_READ;
      seq_q           <= SQ_IDLE;
      byp_q           <= 1'b0;
      sec_q           <= 1'b0;
      bank_q          <= '0;
      busy_q          <= 1'b0;
      go_program      <= 1'b0;
      go_sector_erase <= 1'b0;
      go_chip_erase   <= 1'b0;
      go_suspend      <= 1'b0;
      go_resume       <= 1'b0;
    end else begin
      mode_q          <= mode_n;
      seq_q           <= seq_n;
      byp_q           <= byp_n;
      sec_q           <= sec_n;
      bank_q          <= bank_n;
      busy_q          <= busy;
      go_program      <= p_prog;
      go_sector_erase <= p_sect;
      go_chip_erase   <= p_chip;
      go_suspend      <= p_susp;
      go_resume       <= p_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (cap_en) begin
      cmd_addr <= addr;
      cmd_data <= data;
    end
  end

  assign mode      = (seq_q inside {SQ_EKEY1, SQ_EKEY2, SQ_ECONF}) ? 3'(MD_ERASE_PEND) : 3'(mode_q);
  assign mode_bank = bank_q;

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_program, go_sector_erase, go_chip_erase, go_suspend, go_resume})); // R2

  AST_SUSPEND_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    go_suspend |-> (mode_q == MD_SUSPENDED && $past(mode_q) == MD_ERASING)); // R7

  AST_RESUME_FROM_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    go_resume |-> (mode_q == MD_ERASING && $past(mode_q) == MD_SUSPENDED)); // R7

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_program || go_sector_erase || go_chip_erase) |-> !$past(busy)); // R10

  AST_AUTOSEL_EXIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MD_AUTOSEL && mode_q != MD_AUTOSEL) |-> mode_q == MD_READ); // R4

  AST_ERASE_ENTERS_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
    (go_sector_erase || go_chip_erase) |-> mode_q == MD_ERASING); // R5

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
  parameter int unsigned ADDR_W      = 23,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned KEY_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  output logic [2:0]        mode,
  output logic [BANK_W-1:0] mode_bank,
  output logic              go_program,
  output logic              go_sector_erase,
  output logic              go_chip_erase,
  output logic              go_suspend,
  output logic              go_resume,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  logic [1:0] rst_sync_q;
  logic       rst_ns;
  logic       ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_ns = rst_sync_q[1];

  flash_strobe_sync #(
    .STAGES(SYNC_STAGES)
  ) i_strobe (
    .clk  (clk),
    .rst_n(rst_ns),
    .wr_n (wr_n),
    .ev   (ev)
  );

  flash_cmd_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BANK_W(BANK_W),
    .KEY_W (KEY_W)
  ) i_seq (
    .clk            (clk),
    .rst_n          (rst_ns),
    .ev             (ev),
    .addr           (addr),
    .data           (data),
    .busy           (busy),
    .mode           (mode),
    .mode_bank      (mode_bank),
    .go_program     (go_program),
    .go_sector_erase(go_sector_erase),
    .go_chip_erase  (go_chip_erase),
    .go_suspend     (go_suspend),
    .go_resume      (go_resume),
    .cmd_addr       (cmd_addr),
    .cmd_data       (cmd_data)
  );

endmodule

// File: tb/test_flash_cmd_top.sv
module test_flash_cmd_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [22:0] addr = '0;
  logic [15:0] data = '0;
  logic        busy = 1'b0;
  logic [2:0]  mode;
  logic [2:0]  mode_bank;
  logic        go_program, go_sector_erase, go_chip_erase, go_suspend, go_resume;
  logic [22:0] cmd_addr;
  logic [15:0] cmd_data;

  int checks = 0;
  int errors = 0;
  int n_prog = 0, n_sect = 0, n_chip = 0, n_susp = 0, n_res = 0;
  logic [22:0] last_addr = '0;
  logic [15:0] last_data = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_top i_flash_cmd_top (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .data(data), .busy(busy),
    .mode(mode), .mode_bank(mode_bank), .go_program(go_program),
    .go_sector_erase(go_sector_erase), .go_chip_erase(go_chip_erase),
    .go_suspend(go_suspend), .go_resume(go_resume),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always @(negedge clk) begin
    if (go_program)      n_prog++;
    if (go_sector_erase) n_sect++;
    if (go_chip_erase)   n_chip++;
    if (go_suspend)      n_susp++;
    if (go_resume)       n_res++;
    if (go_program || go_sector_erase || go_chip_erase || go_suspend || go_resume) begin
      last_addr = cmd_addr;
      last_data = cmd_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a;
    data = d;
    wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic prefix();
    wr(23'h000555, 16'h00AA);
    wr(23'h0002AA, 16'h0055);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 0);
    chk("R1 pulses", 32'({go_program, go_sector_erase, go_chip_erase, go_suspend, go_resume}), 0);
  endtask

  task automatic t_program();
    int p = n_prog;
    prefix();
    wr(23'h000555, 16'h00A0);
    wr(23'h123456, 16'hBEEF);
    chk("R2 count", 32'(n_prog - p), 1);
    chk("R2 addr", 32'(last_addr), 32'h123456);
    chk("R2 data", 32'(last_data), 32'hBEEF);
    chk("R2 mode", 32'(mode), 0);
    busy = 1'b1;
    p = n_prog;
    prefix();
    wr(23'h000555, 16'h00A0);
    wr(23'h000100, 16'h1111);
    chk("R10 blocked", 32'(n_prog - p), 0);
    busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_abort();
    int p = n_prog;
    wr(23'h000555, 16'h00AA);
    wr(23'h0002AA, 16'h0056);
    wr(23'h000555, 16'h00A0);
    wr(23'h000100, 16'h1234);
    chk("R3 aborted", 32'(n_prog - p), 0);
    prefix();
    wr(23'h000555, 16'h00A0);
    wr(23'h000200, 16'h4321);
    chk("R3 recovers", 32'(n_prog - p), 1);
  endtask

  task automatic t_masked();
    int p = n_prog;
    wr(23'h3FFD55, 16'h12AA);
    wr(23'h4562AA, 16'hFF55);
    wr(23'h7FF555, 16'h77A0);
    wr(23'h000010, 16'h0055);
    chk("R9 masked program", 32'(n_prog - p), 1);
    chk("R9 data", 32'(last_data), 32'h0055);
  endtask

  task automatic t_autosel();
    int p = n_prog;
    prefix();
    wr(23'h300555, 16'h0090);
    chk("R4 mode", 32'(mode), 1);
    chk("R4 bank", 32'(mode_bank), 3);
    prefix();
    wr(23'h000555, 16'h00A0);
    wr(23'h000300, 16'h5555);
    chk("R4 no pulse", 32'(n_prog - p), 0);
    chk("R4 stays", 32'(mode), 1);
    wr(23'h000000, 16'h00F0);
    chk("R12 reset exits", 32'(mode), 0);
  endtask

  task automatic t_chip();
    int c = n_chip;
    int s = n_susp;
    prefix();
    wr(23'h000555, 16'h0080);
    chk("R5 pending", 32'(mode), 2);
    prefix();
    wr(23'h000123, 16'h0010);
    chk("R5 wrong addr", 32'(n_chip - c), 0);
    chk("R5 wrong addr mode", 32'(mode), 0);
    prefix();
    wr(23'h000555, 16'h0080);
    prefix();
    chk("R5 pending late", 32'(mode), 2);
    wr(23'h000555, 16'h0010);
    chk("R5 chip pulse", 32'(n_chip - c), 1);
    chk("R5 erasing", 32'(mode), 3);
    busy = 1'b1;
    wr(23'h000000, 16'h00B0);
    chk("R7 no chip suspend", 32'(n_susp - s), 0);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 done", 32'(mode), 0);
  endtask

  task automatic t_sector();
    int e = n_sect;
    int s = n_susp;
    int r = n_res;
    wr(23'h200000, 16'h00B0);
    chk("R7 B0 in read", 32'(n_susp - s), 0);
    chk("R7 B0 in read mode", 32'(mode), 0);
    prefix();
    wr(23'h000555, 16'h0080);
    prefix();
    wr(23'h2A8000, 16'h0030);
    chk("R6 pulse", 32'(n_sect - e), 1);
    chk("R6 addr", 32'(last_addr), 32'h2A8000);
    chk("R6 bank", 32'(mode_bank), 2);
    chk("R6 mode", 32'(mode), 3);
    busy = 1'b1;
    wr(23'h100000, 16'h00B0);
    chk("R7 wrong bank", 32'(n_susp - s), 0);
    wr(23'h200000, 16'h00B0);
    chk("R7 suspend", 32'(n_susp - s), 1);
    chk("R7 suspended", 32'(mode), 4);
    wr(23'h200000, 16'h0030);
    chk("R7 resume", 32'(n_res - r), 1);
    chk("R7 resumed", 32'(mode), 3);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 back to read", 32'(mode), 0);
  endtask

  task automatic t_bypass();
    int p = n_prog;
    int e = n_sect;
    prefix();
    wr(23'h000555, 16'h0020);
    chk("R8 enter", 32'(mode), 5);
    wr(23'h000000, 16'h00A0);
    wr(23'h000777, 16'h5A5A);
    chk("R8 short program", 32'(n_prog - p), 1);
    chk("R8 program addr", 32'(last_addr), 32'h000777);
    wr(23'h000000, 16'h0080);
    chk("R8 pending", 32'(mode), 2);
    wr(23'h100000, 16'h0030);
    chk("R8 short erase", 32'(n_sect - e), 1);
    busy = 1'b1;
    repeat (2) @(negedge clk);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 home bypass", 32'(mode), 5);
    wr(23'h000000, 16'h0090);
    wr(23'h000000, 16'h0000);
    chk("R8 exit", 32'(mode), 0);
    p = n_prog;
    wr(23'h000000, 16'h00A0);
    wr(23'h000777, 16'h5A5A);
    chk("R8 no short after exit", 32'(n_prog - p), 0);
  endtask

  task automatic t_f0_mid();
    int p = n_prog;
    prefix();
    wr(23'h000000, 16'h00F0);
    wr(23'h000555, 16'h00A0);
    wr(23'h000400, 16'h9999);
    chk("R12 mid reset", 32'(n_prog - p), 0);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_program();
    t_abort();
    t_masked();
    t_autosel();
    t_chip();
    t_sector();
    t_bypass();
    t_f0_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule